// File: doc/BRIEF.md
# Flash Erase-Then-Record Sequencer

This controller re-records a fixed-length announcement into an in-system-programmable flash array, and it can also stream that announcement back out. A record request starts a full-array erase: the controller raises an erase strobe for one cycle and then waits until the flash drops its busy flag. After that it runs a write sweep. In each cycle of the sweep it tells the analog-to-digital converter to load a sample and drive it onto the shared data bus, and it writes that bus word to the flash at the current address. The sweep runs from address 0 to the top of the array.

A play request runs a read sweep over the same addresses. In the cycle after each read it pulses the digital-to-analog converter load, which is when the read word sits on the bus. While a pass is in progress, new requests are ignored. The sweep counter is one bit wider than the flash address, and a pass ends when that counter reaches the array depth. All outputs are registers.

Top module: `fes_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, every strobe output is 0 and the flash address is 0.
- R2: A record request sampled while idle makes the flash erase output 1 in the next cycle, for exactly one cycle.
- R3: After the erase pulse, no flash access takes place while busy is 1. The write sweep starts in the cycle after busy is sampled 0. Erase and flash enable are never 1 together, and no write is issued while busy is 1.
- R4: A write sweep lasts 4096 consecutive cycles with addresses 0, 1, ... 4095 in order. In each of these cycles flash enable, write-select (1 = write), ADC load and ADC bus drive are all 1.
- R5: In the cycle after the access at address 4095, every strobe is 0 and the address returns to 0.
- R6: A play request sampled while idle starts 4096 consecutive read cycles: enable 1, write-select 0, ADC strobes 0, and addresses ascending from 0.
- R7: DAC load is 1 exactly in the cycle after each read cycle, so one read sweep produces 4096 pulses.
- R8: Record and play requests that arrive during an erase, a busy wait, a write sweep or a read sweep have no effect.
- R9: When record and play are requested in the same idle cycle, record wins. No read sweep follows.
- R10: While idle with no request, all strobes stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_req | input | 1 | Request to erase and re-record |
| play_req | input | 1 | Request to stream the stored samples out |
| flash_busy | input | 1 | Flash erase in progress |
| flash_addr | output | 12 | Flash word address |
| flash_wr_sel | output | 1 | 1 = write, 0 = read |
| flash_en | output | 1 | Flash access enable |
| flash_erase | output | 1 | Whole-array erase strobe |
| adc_load | output | 1 | ADC sample load |
| adc_bus_en | output | 1 | ADC drives the data bus |
| dac_load | output | 1 | DAC latches the data bus |

## Verification
A wrong state register shows up at the strobe outputs in the very next cycle. Examples are an erase that lasts too long, a sweep that starts before busy clears, or a write pass that starts when play was requested. The bench compares every output on every clock, so such faults are caught at once. A counter fault, such as a skipped address or an off-by-one at the end, shows in the address or in the first cycle after the sweep. The flash model in the bench counts erases, writes, reads and DAC pulses per pass. These counts expose restarted or truncated passes and any write issued while busy.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ERASE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_PLAY  = 3'd4
  } fes_state_e;

  typedef struct packed {
    logic erase;
    logic en;
    logic wr_sel;
    logic adc_load;
    logic adc_bus;
  } fes_strobe_t;

  function automatic fes_strobe_t fes_decode(input fes_state_e st);
    fes_strobe_t s;
    s.erase    = (st == ST_ERASE);
    s.en       = (st == ST_WRITE) || (st == ST_PLAY);
    s.wr_sel   = (st == ST_WRITE);
    s.adc_load = (st == ST_WRITE);
    s.adc_bus  = (st == ST_WRITE);
    return s;
  endfunction
endpackage

// File: rtl/fes_sweep_counter.sv
module fes_sweep_counter #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap
);
  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sum;

  // the sweep ends once the wide counter reaches the array depth
  assign sum  = cnt_q + CNT_W'(1);
  assign wrap = sum[ADDR_W];
  assign addr = cnt_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || !advance) cnt_q <= '0;
    else if (wrap)       cnt_q <= '0;
    else                 cnt_q <= sum;
  end
endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rec_req,
  input  logic       play_req,
  input  logic       busy,
  input  logic       wrap,
  output fes_state_e st_q,
  output fes_state_e st_next,
  output logic       advance
);
  always_comb begin
    st_next = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (rec_req)       st_next = ST_ERASE;
        else if (play_req) st_next = ST_PLAY;
      end
      ST_ERASE: st_next = ST_WAIT;
      ST_WAIT:  if (!busy) st_next = ST_WRITE;
      ST_WRITE, ST_PLAY: if (wrap) st_next = ST_IDLE;
      default:  st_next = ST_IDLE;
    endcase
  end

  assign advance = (st_q == ST_WRITE) || (st_q == ST_PLAY);

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_next;
  end
endmodule

// File: rtl/fes_strobe_regs.sv
module fes_strobe_regs
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  fes_state_e st_q,
  input  fes_state_e st_next,
  output logic       erase,
  output logic       en,
  output logic       wr_sel,
  output logic       adc_load,
  output logic       adc_bus,
  output logic       dac_load
);
  fes_strobe_t nxt, q;

  assign nxt = fes_decode(st_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      dac_load <= 1'b0;
    end else begin
      q        <= nxt;
      dac_load <= (st_q == ST_PLAY);
    end
  end

  assign erase    = q.erase;
  assign en       = q.en;
  assign wr_sel   = q.wr_sel;
  assign adc_load = q.adc_load;
  assign adc_bus  = q.adc_bus;
endmodule

// File: rtl/fes_sequencer.sv
module fes_sequencer
  import fes_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_req,
  input  logic              play_req,
  input  logic              flash_busy,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_wr_sel,
  output logic              flash_en,
  output logic              flash_erase,
  output logic              adc_load,
  output logic              adc_bus_en,
  output logic              dac_load
);
  fes_state_e st_q, st_next;
  logic       advance, wrap;

  fes_ctrl ctrl_i (
    .clk(clk), .rst(rst), .rec_req(rec_req), .play_req(play_req),
    .busy(flash_busy), .wrap(wrap), .st_q(st_q), .st_next(st_next),
    .advance(advance)
  );

  fes_sweep_counter #(.ADDR_W(ADDR_W)) cnt_i (
    .clk(clk), .rst(rst), .advance(advance), .addr(flash_addr), .wrap(wrap)
  );

  fes_strobe_regs strb_i (
    .clk(clk), .rst(rst), .st_q(st_q), .st_next(st_next),
    .erase(flash_erase), .en(flash_en), .wr_sel(flash_wr_sel),
    .adc_load(adc_load), .adc_bus(adc_bus_en), .dac_load(dac_load)
  );
endmodule

// File: rtl/fes_sequencer_chk.sv
module fes_sequencer_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              rec_req,
  input logic              flash_busy,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              flash_wr_sel,
  input logic              flash_en,
  input logic              flash_erase,
  input logic              adc_load,
  input logic              adc_bus_en,
  input logic              dac_load
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  // R2
  erase_single_chk: assert property (@(posedge clk) disable iff (rst)
    flash_erase |=> !flash_erase);

  // R2
  erase_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_erase) |-> $past(rec_req));

  // R3
  erase_vs_access_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flash_erase, flash_en}));

  // R3
  erase_then_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    flash_erase |=> !flash_en);

  // R3
  no_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_en && flash_wr_sel) |-> !flash_busy);

  // R4
  write_step_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_en && flash_wr_sel && flash_addr != LAST) |=>
      (flash_en && flash_wr_sel && flash_addr == $past(flash_addr) + 1'b1));

  // R4
  write_adc_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_en && flash_wr_sel) |-> (adc_load && adc_bus_en));

  // R5
  sweep_end_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_en && flash_addr == LAST) |=> (!flash_en && flash_addr == '0));

  // R6
  read_no_adc_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_en && !flash_wr_sel) |-> (!adc_load && !adc_bus_en));

  // R7
  dac_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_en && !flash_wr_sel) |=> dac_load);

  // R7
  dac_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_load) |-> $past(flash_en && !flash_wr_sel));
endmodule

bind fes_sequencer fes_sequencer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .rec_req(rec_req), .flash_busy(flash_busy),
  .flash_addr(flash_addr), .flash_wr_sel(flash_wr_sel), .flash_en(flash_en),
  .flash_erase(flash_erase), .adc_load(adc_load), .adc_bus_en(adc_bus_en),
  .dac_load(dac_load)
);

// File: tb/fes_sequencer_tb_top.sv
module fes_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rec_req = 1'b0;
  logic play_req = 1'b0;
  logic flash_busy;
  logic [ADDR_W-1:0] flash_addr;
  logic flash_wr_sel, flash_en, flash_erase, adc_load, adc_bus_en, dac_load;

  always #(CLK_PERIOD/2) clk = ~clk;

  fes_sequencer #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .rec_req(rec_req), .play_req(play_req),
    .flash_busy(flash_busy), .flash_addr(flash_addr),
    .flash_wr_sel(flash_wr_sel), .flash_en(flash_en),
    .flash_erase(flash_erase), .adc_load(adc_load),
    .adc_bus_en(adc_bus_en), .dac_load(dac_load)
  );

  // flash model: busy rises the cycle after the erase strobe
  int erase_len = 8;
  int left = 0;
  int erase_cnt = 0, write_cnt = 0, read_cnt = 0, dac_cnt = 0, busy_wr = 0;
  always @(posedge clk) begin
    if (rst) begin
      flash_busy <= 1'b0;
      left <= 0;
    end else begin
      if (flash_busy) begin
        if (left <= 1) flash_busy <= 1'b0;
        left <= left - 1;
      end else if (flash_erase) begin
        flash_busy <= 1'b1;
        left <= erase_len;
      end
      if (flash_erase) erase_cnt <= erase_cnt + 1;
      if (flash_en && flash_wr_sel) begin
        write_cnt <= write_cnt + 1;
        if (flash_busy) busy_wr <= busy_wr + 1;
      end
      if (flash_en && !flash_wr_sel) read_cnt <= read_cnt + 1;
      if (dac_load) dac_cnt <= dac_cnt + 1;
    end
  end

  int n_checks = 0, n_err = 0;
  // reference model: 0 idle, 1 erase, 2 wait, 3 write, 4 play
  int m_mode = 0, m_idx = 0;
  bit m_dac = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic [5:0] exp_v, act_v;
    string tag;
    exp_v = {m_mode == 1, m_mode == 3 || m_mode == 4, m_mode == 3,
             m_mode == 3, m_mode == 3, 1'b0};
    act_v = {flash_erase, flash_en, flash_wr_sel, adc_load, adc_bus_en, 1'b0};
    case (m_mode)
      1: tag = "R2";
      2: tag = "R3";
      3: tag = "R4";
      4: tag = "R6";
      default: tag = "R10/R5";
    endcase
    check(act_v == exp_v && int'(flash_addr) == m_idx, tag,
          {act_v, 12'(flash_addr)}, {exp_v, 12'(m_idx)});
    check(dac_load == m_dac, "R7", dac_load, m_dac);
  endtask

  task automatic model_step(input bit r, input bit p, input bit b);
    bit nd;
    nd = (m_mode == 4);
    case (m_mode)
      0: if (r) m_mode = 1; else if (p) begin m_mode = 4; m_idx = 0; end
      1: m_mode = 2;
      2: if (!b) begin m_mode = 3; m_idx = 0; end
      default: if (m_idx == DEPTH - 1) begin m_mode = 0; m_idx = 0; end
               else m_idx++;
    endcase
    m_dac = nd;
  endtask

  task automatic cyc(input bit r, input bit p);
    @(negedge clk);
    check_outputs();
    rec_req = r;
    play_req = p;
    model_step(r, p, flash_busy);
  endtask

  // R8: requests injected mid-pass must not disturb the sweep
  task automatic run_pass(input int rec_at, input int play_at);
    for (int k = 0; k < 20000; k++) begin
      cyc(k == rec_at, k == play_at);
      if (m_mode == 0 && !m_dac) break;
    end
    cyc(0, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_err++;
    $display("FAIL R4: watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check({flash_erase, flash_en, flash_wr_sel, adc_load, adc_bus_en, dac_load} == 6'b0
          && flash_addr == '0, "R1", flash_addr, 0);
    rst = 1'b0;
    cyc(0, 0);
    // R10
    repeat (5) cyc(0, 0);

    // R6 / R7 / R8: play with stray requests inside the sweep
    cyc(0, 1);
    run_pass(100, 200);
    check(read_cnt == DEPTH, "R6", read_cnt, DEPTH);
    check(dac_cnt == DEPTH, "R7", dac_cnt, DEPTH);
    check(write_cnt == 0 && erase_cnt == 0, "R8", write_cnt + erase_cnt, 0);

    // R2 / R3 / R4 / R8: record, stray requests in the wait and the sweep
    erase_len = 20;
    cyc(1, 0);
    run_pass(10, 30);
    check(erase_cnt == 1, "R2", erase_cnt, 1);
    check(write_cnt == DEPTH, "R4", write_cnt, DEPTH);
    check(busy_wr == 0, "R3", busy_wr, 0);
    check(read_cnt == DEPTH, "R8", read_cnt, DEPTH);

    // R9: simultaneous requests, record wins
    erase_len = 3;
    cyc(1, 1);
    cyc(0, 0);
    check(flash_erase && !flash_en, "R9", {flash_erase, flash_en}, 2'b10);
    run_pass(2000, 3000);
    check(erase_cnt == 2 && write_cnt == 2 * DEPTH, "R9", write_cnt, 2 * DEPTH);
    check(read_cnt == DEPTH, "R9", read_cnt, DEPTH);
    check(busy_wr == 0, "R3", busy_wr, 0);

    // R6 / R7: second playback
    cyc(0, 1);
    run_pass(-1, 50);
    check(read_cnt == 2 * DEPTH, "R6", read_cnt, 2 * DEPTH);
    check(dac_cnt == 2 * DEPTH, "R7", dac_cnt, 2 * DEPTH);
    // R5
    check(!flash_en && flash_addr == '0, "R5", flash_addr, 0);

    summary();
    $finish;
  end
endmodule